// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block carries out one read transaction against a serial NOR flash over up to four data lanes. A transaction is opened by a one-cycle start request. The block then sends an 8-bit opcode and a 24-bit address, sends an optional mode byte, waits a programmable number of idle clocks, and finally receives the requested number of bytes. The opcode, address and data phases each pick their own lane count of 1, 2 or 4, so the block covers plain single-lane reads, fast reads and dual or quad reads.

The serial clock runs at half the system clock. It idles low, and cs_n is held low for the whole transaction. The block changes its outputs on the serial clock's falling edge and samples the flash on the rising edge. Received bits are assembled into bytes. Each byte appears on `rd_data` together with a one-cycle `rd_valid` pulse. All configuration is captured when a start request is accepted, so it may change freely while a transaction is running.

Top module: `qflash_read_seq`

## Requirements
- R1: When `busy` is low, a high `start` is accepted at the clock edge. From the next cycle on, `busy` is high, `cs_n` is low and `sclk` is low. A `start` that arrives while `busy` is high, and any change to the configuration inputs during that time, has no effect on the running transaction.
- R2: `sclk` is low whenever `cs_n` is high. Every serial clock lasts two system cycles, with the low half first and the high half second.
- R3: A lane code of 0 or 3 selects one lane (DQ0). Code 1 selects two lanes (DQ1:DQ0) and code 2 selects four lanes (DQ3:DQ0). Within one serial clock, the higher lane carries the more significant bit. A driven phase enables exactly the selected lanes on `dq_oe`.
- R4: The opcode phase sends the 8 bits of `rd_opcode`, MSB first, at the `inst_lanes` width.
- R5: The address phase follows directly and sends all `ADDR_W` bits of `rd_addr`, MSB first, at the `addr_lanes` width.
- R6: When `mode_en` is set, `mode_byte` is sent MSB first at the `addr_lanes` width directly after the last address clock. When `mode_en` is clear, the mode phase is skipped.
- R7: Next come `dummy_clks` serial clocks (0 to 31). During these clocks every `dq_oe` bit is low and `dq_i` is ignored. A value of 0 starts the data phase immediately.
- R8: In the data phase all `dq_oe` bits are low. `dq_i` is sampled at each `sclk` rising edge on the `data_lanes` width and packed MSB first. Each completed byte is shown on `rd_data` with `rd_valid` high for exactly the cycle of that clock's high half. Exactly `rd_bytes` bytes are read, and a count of 0 skips the data phase.
- R9: `cs_n` goes high in the cycle after the high half of the last serial clock. `busy` drops one cycle later.
- R10: A lane whose `dq_oe` bit is low drives 0 on its `dq_o` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a read |
| busy | output | 1 | High while a transaction is running |
| rd_opcode | input | 8 | Opcode to send |
| rd_addr | input | ADDR_W | Read address |
| mode_en | input | 1 | Insert the mode byte after the address |
| mode_byte | input | 8 | Mode byte value |
| dummy_clks | input | DUMMY_W | Number of idle clocks before the data phase |
| inst_lanes | input | 2 | Lane code for the opcode phase |
| addr_lanes | input | 2 | Lane code for the address and mode phases |
| data_lanes | input | 2 | Lane code for the data phase |
| rd_bytes | input | NB_W | Number of bytes to read |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| dq_o | output | 4 | Per-lane output data |
| dq_oe | output | 4 | Per-lane output enable |
| dq_i | input | 4 | Per-lane input data |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |

## Verification
The bench builds the block with `ADDR_W` = 24, `DUMMY_W` = 5 and `NB_W` reduced to 4. The reduced byte count keeps every transaction short enough that each one can be followed cycle by cycle. The full 5-bit dummy range is kept, so both dummy extremes, 0 and 31, are within reach. With these values the bench can exercise every lane code, including the reserved code 3, as well as mixed widths across phases, the mode byte with and without idle clocks, a zero-byte read, and a new start in the first cycle after `busy` drops.

// File: rtl/qflash_read_seq.sv
module qflash_read_seq #(
  parameter int ADDR_W  = 24,
  parameter int NB_W    = 8,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  input  logic [7:0]         rd_opcode,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               mode_en,
  input  logic [7:0]         mode_byte,
  input  logic [DUMMY_W-1:0] dummy_clks,
  input  logic [1:0]         inst_lanes,
  input  logic [1:0]         addr_lanes,
  input  logic [1:0]         data_lanes,
  input  logic [NB_W-1:0]    rd_bytes,
  output logic               sclk,
  output logic               cs_n,
  output logic [3:0]         dq_o,
  output logic [3:0]         dq_oe,
  input  logic [3:0]         dq_i,
  output logic [7:0]         rd_data,
  output logic               rd_valid
);

  localparam int DATA_CW = NB_W + 3;
  localparam int ADDR_CW = $clog2(ADDR_W + 1);
  localparam int CNT_A   = (DATA_CW > DUMMY_W) ? DATA_CW : DUMMY_W;
  localparam int CNT_W   = (CNT_A > ADDR_CW) ? CNT_A : ADDR_CW;

  typedef enum logic [2:0] {P_IDLE, P_CMD, P_ADDR, P_MODE, P_DUMMY, P_DATA, P_END} ph_t;

  ph_t ph, ph_nx, ph_post;
  logic [1:0]         lg_i, lg_a, lg_d, lg_out;
  logic [ADDR_W-1:0]  sh, sh_ld, addr_q, mode_al;
  logic [CNT_W-1:0]   cnt, cnt_ld;
  logic               men_q;
  logic [7:0]         mode_q, rx, rx_nx;
  logic [DUMMY_W-1:0] dum_q;
  logic [NB_W-1:0]    nb_q;
  logic [2:0]         rbits;
  logic [3:0]         rbits_sum;
  logic               drive;

  function automatic logic [1:0] lane_lg(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  assign drive     = ph inside {P_CMD, P_ADDR, P_MODE};
  assign lg_out    = (ph == P_CMD) ? lg_i : lg_a;
  assign mode_al   = ADDR_W'(mode_q) << (ADDR_W - 8);
  assign rbits_sum = {1'b0, rbits} + (4'd1 << lg_d);

  always_comb begin
    dq_o  = 4'h0;
    dq_oe = 4'h0;
    if (drive) begin
      case (lg_out)
        2'd0: begin
          dq_o[0] = sh[ADDR_W-1];
          dq_oe   = 4'b0001;
        end
        2'd1: begin
          dq_o[1:0] = sh[ADDR_W-1 -: 2];
          dq_oe     = 4'b0011;
        end
        default: begin
          dq_o  = sh[ADDR_W-1 -: 4];
          dq_oe = 4'b1111;
        end
      endcase
    end
  end

  always_comb begin
    case (lg_d)
      2'd0:    rx_nx = {rx[6:0], dq_i[0]};
      2'd1:    rx_nx = {rx[5:0], dq_i[1:0]};
      default: rx_nx = {rx[3:0], dq_i[3:0]};
    endcase
  end

  always_comb begin
    ph_post = (dum_q != '0) ? P_DUMMY : ((nb_q != '0) ? P_DATA : P_END);
    case (ph)
      P_CMD:   ph_nx = P_ADDR;
      P_ADDR:  ph_nx = men_q ? P_MODE : ph_post;
      P_MODE:  ph_nx = ph_post;
      P_DUMMY: ph_nx = (nb_q != '0) ? P_DATA : P_END;
      default: ph_nx = P_END;
    endcase
    sh_ld  = '0;
    cnt_ld = '0;
    case (ph_nx)
      P_ADDR: begin
        sh_ld  = addr_q;
        cnt_ld = CNT_W'(ADDR_W >> lg_a) - CNT_W'(1);
      end
      P_MODE: begin
        sh_ld  = mode_al;
        cnt_ld = CNT_W'(8 >> lg_a) - CNT_W'(1);
      end
      P_DUMMY: cnt_ld = CNT_W'(dum_q) - CNT_W'(1);
      P_DATA:  cnt_ld = CNT_W'({nb_q, 3'b000} >> lg_d) - CNT_W'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= P_IDLE;
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      addr_q   <= '0;
      lg_i     <= 2'd0;
      lg_a     <= 2'd0;
      lg_d     <= 2'd0;
      men_q    <= 1'b0;
      mode_q   <= 8'h0;
      dum_q    <= '0;
      nb_q     <= '0;
      rx       <= 8'h0;
      rbits    <= 3'd0;
      rd_data  <= 8'h0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (ph)
        P_IDLE: begin
          if (start) begin
            ph     <= P_CMD;
            busy   <= 1'b1;
            cs_n   <= 1'b0;
            sclk   <= 1'b0;
            lg_i   <= lane_lg(inst_lanes);
            lg_a   <= lane_lg(addr_lanes);
            lg_d   <= lane_lg(data_lanes);
            addr_q <= rd_addr;
            men_q  <= mode_en;
            mode_q <= mode_byte;
            dum_q  <= dummy_clks;
            nb_q   <= rd_bytes;
            sh     <= ADDR_W'(rd_opcode) << (ADDR_W - 8);
            cnt    <= CNT_W'(8 >> lane_lg(inst_lanes)) - CNT_W'(1);
            rx     <= 8'h0;
            rbits  <= 3'd0;
          end
        end
        P_END: begin
          busy <= 1'b0;
          ph   <= P_IDLE;
        end
        default: begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (ph == P_DATA) begin
              rx    <= rx_nx;
              rbits <= rbits_sum[2:0];
              if (rbits_sum[3]) begin
                rd_data  <= rx_nx;
                rd_valid <= 1'b1;
              end
            end
          end else begin
            sclk <= 1'b0;
            if (cnt == '0) begin
              ph  <= ph_nx;
              sh  <= sh_ld;
              cnt <= cnt_ld;
              if (ph_nx == P_END) cs_n <= 1'b1;
            end else begin
              cnt <= cnt - CNT_W'(1);
              sh  <= sh << (3'd1 << lg_out);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/qflash_read_seq_chk.sv
module qflash_read_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       sclk,
  input logic       cs_n,
  input logic [3:0] dq_o,
  input logic [3:0] dq_oe,
  input logic       rd_valid
);

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !cs_n && !sclk));

  // R1
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R2
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk) |=> !sclk);

  // R3
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe inside {4'h0, 4'h1, 4'h3, 4'hF});

  // R10
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_o & ~dq_oe) == 4'h0);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  valid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (sclk && !cs_n && dq_oe == 4'h0));

  // R9
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);

  // R9
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !busy);

endmodule

bind qflash_read_seq qflash_read_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sclk(sclk),
  .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/qflash_read_seq_tb_top.sv
`timescale 1ns/1ps
module qflash_read_seq_tb_top;

  localparam int ADDR_W = 24;
  localparam int NB_W = 4;
  localparam int DUMMY_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy;
  logic [7:0] rd_opcode = 8'h0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic mode_en = 1'b0;
  logic [7:0] mode_byte = 8'h0;
  logic [DUMMY_W-1:0] dummy_clks = '0;
  logic [1:0] inst_lanes = 2'd0;
  logic [1:0] addr_lanes = 2'd0;
  logic [1:0] data_lanes = 2'd0;
  logic [NB_W-1:0] rd_bytes = '0;
  logic sclk, cs_n, rd_valid;
  logic [3:0] dq_o, dq_oe;
  logic [3:0] dq_i = 4'h0;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  qflash_read_seq #(.ADDR_W(ADDR_W), .NB_W(NB_W), .DUMMY_W(DUMMY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rd_opcode(rd_opcode), .rd_addr(rd_addr), .mode_en(mode_en), .mode_byte(mode_byte),
    .dummy_clks(dummy_clks), .inst_lanes(inst_lanes), .addr_lanes(addr_lanes),
    .data_lanes(data_lanes), .rd_bytes(rd_bytes), .sclk(sclk), .cs_n(cs_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct packed {
    logic       cs_n;
    logic       sclk;
    logic       busy;
    logic [3:0] oe;
    logic [3:0] dq;
    logic       vld;
    logic [7:0] data;
    logic [3:0] din;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int checks = 0;
  int failures = 0;
  int wd = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<=100000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lanes(input logic [1:0] code);
    if (code == 2'd1) return 2;
    if (code == 2'd2) return 4;
    return 1;
  endfunction

  task automatic push(input logic c, input logic s, input logic [3:0] oe, input logic [3:0] dq,
                      input logic v, input logic [7:0] d, input logic [3:0] din, input string tag);
    exp_t e;
    e.cs_n = c; e.sclk = s; e.busy = 1'b1; e.oe = oe; e.dq = dq;
    e.vld = v; e.data = d; e.din = din;
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic out_field(input logic [31:0] v, input int nbits, input int w, input string tag);
    for (int c = 0; c < nbits / w; c++) begin
      logic [3:0] dq;
      dq = 4'h0;
      for (int j = 0; j < w; j++) dq[w-1-j] = v[nbits-1-c*w-j];
      push(1'b0, 1'b0, 4'((1 << w) - 1), dq, 1'b0, 8'h0, 4'h0, tag);
      push(1'b0, 1'b1, 4'((1 << w) - 1), dq, 1'b0, 8'h0, 4'h0, tag);
    end
  endtask

  task automatic build(input logic [7:0] op, input logic [23:0] ad, input logic men, input logic [7:0] mb,
                       input int dum, input logic [1:0] wi, input logic [1:0] wa, input logic [1:0] wdc,
                       input int nb, input int seed);
    logic [7:0] bt[16];
    int w;
    eq.delete();
    tq.delete();
    out_field(32'(op), 8, lanes(wi), "R3/R4");
    out_field(32'(ad), 24, lanes(wa), "R3/R5");
    if (men) out_field(32'(mb), 8, lanes(wa), "R6");
    for (int k = 0; k < dum; k++) begin
      push(1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 8'h0, 4'hA, "R7");
      push(1'b0, 1'b1, 4'h0, 4'h0, 1'b0, 8'h0, 4'hA, "R7");
    end
    for (int i = 0; i < 16; i++) bt[i] = 8'((seed * 29 + i * 71) ^ 8'hC3);
    w = lanes(wdc);
    for (int c = 0; c < nb * 8 / w; c++) begin
      logic [3:0] din;
      logic v;
      din = 4'h0;
      for (int j = 0; j < w; j++) begin
        int idx;
        idx = c * w + j;
        din[w-1-j] = bt[idx / 8][7 - (idx % 8)];
      end
      v = (((c + 1) * w) % 8) == 0;
      push(1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 8'h0, din, "R8");
      push(1'b0, 1'b1, 4'h0, 4'h0, v, v ? bt[((c + 1) * w) / 8 - 1] : 8'h0, din, "R8");
    end
    push(1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 8'h0, 4'h0, "R9");
  endtask

  task automatic tick();
    exp_t e;
    string tg;
    @(negedge clk);
    if (eq.size() > 0) begin
      e = eq.pop_front();
      tg = tq.pop_front();
    end else begin
      e.cs_n = 1'b1; e.sclk = 1'b0; e.busy = 1'b0; e.oe = 4'h0; e.dq = 4'h0;
      e.vld = 1'b0; e.data = 8'h0; e.din = 4'h0;
      tg = "R10";
    end
    chk(32'(cs_n), 32'(e.cs_n), "R2", "cs_n");
    chk(32'(sclk), 32'(e.sclk), "R2", "sclk");
    chk(32'(busy), 32'(e.busy), "R1/R9", "busy");
    chk(32'(dq_oe), 32'(e.oe), tg, "dq_oe");
    chk(32'(dq_o), 32'(e.dq), tg, "dq_o");
    chk(32'(rd_valid), 32'(e.vld), "R8", "rd_valid");
    if (e.vld) chk(32'(rd_data), 32'(e.data), "R8", "rd_data");
    dq_i = e.din;
  endtask

  task automatic launch(input logic [7:0] op, input logic [23:0] ad, input logic men, input logic [7:0] mb,
                        input int dum, input logic [1:0] wi, input logic [1:0] wa, input logic [1:0] wdc,
                        input int nb, input int seed);
    while (eq.size() != 0) tick();
    tick();
    rd_opcode = op; rd_addr = ad; mode_en = men; mode_byte = mb;
    dummy_clks = DUMMY_W'(dum); inst_lanes = wi; addr_lanes = wa; data_lanes = wdc;
    rd_bytes = NB_W'(nb);
    start = 1'b1;
    build(op, ad, men, mb, dum, wi, wa, wdc, nb, seed);
    tick();
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state: idle outputs while reset is held
    chk(32'(busy), 32'd0, "R1", "busy in reset");
    chk(32'(cs_n), 32'd1, "R2", "cs_n in reset");
    chk(32'(sclk), 32'd0, "R2", "sclk in reset");
    chk(32'(dq_oe), 32'd0, "R10", "dq_oe in reset");
    rst_n = 1'b1;
    repeat (3) tick();

    // R4 R5 R8: all single lane, plain read
    launch(8'h03, 24'h123456, 1'b0, 8'h00, 0, 2'd0, 2'd0, 2'd0, 2, 1);

    // R3 R6 R7: quad everywhere, mode byte and dummy clocks
    launch(8'hEB, 24'hA5C3F0, 1'b1, 8'hF0, 4, 2'd2, 2'd2, 2'd2, 3, 2);
    repeat (10) tick();
    // R1: start with a different setup while busy must be ignored
    rd_opcode = 8'h55; rd_addr = 24'h000000; inst_lanes = 2'd0; data_lanes = 2'd0;
    rd_bytes = NB_W'(9); dummy_clks = DUMMY_W'(1);
    start = 1'b1;
    tick();
    start = 1'b0;

    // R3 R7: dual opcode and address, quad data, eight dummy clocks
    launch(8'h0B, 24'hFFFFFF, 1'b0, 8'h00, 8, 2'd1, 2'd1, 2'd2, 1, 3);

    // R3: reserved code 3 behaves as single lane; R7 maximum dummy count
    launch(8'h6B, 24'h000001, 1'b1, 8'h5A, 31, 2'd3, 2'd3, 2'd3, 2, 4);

    // R8: zero byte count skips the data phase; R9 ends right after address
    launch(8'h3B, 24'h800000, 1'b0, 8'h00, 0, 2'd0, 2'd1, 2'd1, 0, 5);

    // R6: mode byte followed directly by data (no dummy), mixed widths
    launch(8'hBB, 24'h0F0F0F, 1'b1, 8'hA5, 0, 2'd1, 2'd2, 2'd0, 4, 6);

    // R8: dual data with longest byte run
    launch(8'h3B, 24'h5A5A5A, 1'b0, 8'h00, 2, 2'd0, 2'd0, 2'd1, 15, 7);

    while (eq.size() != 0) tick();
    repeat (3) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule